// File: doc/BRIEF.md
# Instruction Address Sequencer with Trap Redirection

This block holds the 17-bit virtual instruction address of the program status and decides where the next instruction comes from. It qualifies every fetch against access-check results that arrive in the same cycle as the address. A fetch with good status advances the address by one, so that it points at the next sequential instruction. A fetch with bad status sends control to a fixed fetch-trap location.

When the current instruction finishes, the block takes one of three paths. It keeps the sequential address, or it jumps to the branch effective address when the branch condition holds, or it vectors to a trap. When it traps, it reports the address of the instruction that trapped, which is the updated address minus one. Only the path that is actually taken gets an access check. A failing indirect pointer or a failing branch target causes a nonallowed-operation trap, and only when the branch is taken. Decode and arithmetic live elsewhere and drive this block through plain strobes.

Top module: `iaddr_seq`

## Requirements
- R1: After reset `fetch_addr_o` is 0, `trap_o` is 0 and `trap_cause_o` is 0.
- R2: A fetch (`fetch_req_i`=1) that passes the access check sets `fetch_addr_o` to its old value plus 1 on the next edge, modulo 2^17 (0x1FFFF wraps to 0).
- R3: A fetch whose address is nonexistent (`exist_i`=0), or lacks instruction access (`exec_ok_i`=0) while protection applies, loads 0x40. It pulses `trap_o` with cause 1 and `trap_ret_o` equal to the unincremented address.
- R4: `mode_i` encodes 00 slave, 01 master, 10 master-protected, and 11 behaves as slave. In master mode only existence is checked and the access bits are ignored. In every other mode the protection checks apply.
- R5: At the end of an instruction (`end_i`=1) with no trap and no taken branch, `fetch_addr_o` keeps the updated address.
- R6: At the end of an instruction with `br_taken_i`=1, no fault and no trap request, `fetch_addr_o` becomes `br_ea_i`.
- R7: `trap_req_i` at the end of an instruction overrides every other path. It loads `trap_vec_i`, pulses `trap_o` with cause 3 and sets `trap_ret_o` to the updated address minus 1, modulo 2^17.
- R8: A taken branch with `indirect_i`=1 and `ptr_ok_i`=0 aborts and traps to the nonallowed-operation vector (default 0x4D) with cause 2 and the rolled-back address. An untaken branch never checks the pointer.
- R9: A taken branch whose target is nonexistent, or lacks instruction or read access while protection applies, traps as in R8.
- R10: For an untaken branch the access-check inputs are ignored, so no trap is raised even when they report a fault.
- R11: `chk_addr_o` names the address the access inputs qualify. It shows `br_ea_i` during an end strobe without a fetch strobe, and `fetch_addr_o` at all other times.
- R12: When `fetch_req_i` and `end_i` are both high, the fetch is performed and the end strobe is ignored.
- R13: `trap_o` is a single-cycle pulse. In a cycle without a trap event, `trap_o` is 0 and `trap_cause_o` is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Privilege mode (00 slave, 01 master, 10 master-protected) |
| fetch_req_i | input | 1 | Fetch the instruction at the current address |
| end_i | input | 1 | Current instruction completes this cycle |
| br_taken_i | input | 1 | Branch condition satisfied |
| br_ea_i | input | 17 | Branch effective address |
| indirect_i | input | 1 | Branch is indirectly addressed |
| ptr_ok_i | input | 1 | Indirect pointer location exists and is readable |
| trap_req_i | input | 1 | Trap raised during execution |
| trap_vec_i | input | 17 | Location for the requested trap |
| exist_i | input | 1 | Address on chk_addr_o exists |
| exec_ok_i | input | 1 | Address on chk_addr_o allows instruction access |
| read_ok_i | input | 1 | Address on chk_addr_o allows read access |
| chk_addr_o | output | 17 | Address being qualified this cycle |
| fetch_addr_o | output | 17 | Instruction address (status bits 15-31) |
| trap_o | output | 1 | Trap taken on the previous edge |
| trap_cause_o | output | 2 | 0 none, 1 fetch, 2 nonallowed operation, 3 requested |
| trap_ret_o | output | 17 | Address of the trapping instruction |

## Verification
The bench checks the rollback at the zero boundary. A requested trap raised right after the address wraps must report 0x1FFFF, and a design that skipped the decrement or did not wrap would report 0 or an 18-bit value. It also gives an untaken branch a faulty target and a bad indirect pointer. A design that checked ahead of time would trap there when it should have run on. Master-mode fetches and branches with the protection bits cleared confirm that the mode gating holds, and a fetch and an end strobe in the same cycle show whether the fetch wins.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;
  localparam int unsigned ADDR_W = 17;

  typedef enum logic [1:0] {
    MODE_SLAVE  = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_MPROT  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FETCH = 2'd1,
    CAUSE_NAO   = 2'd2,
    CAUSE_REQ   = 2'd3
  } cause_e;
endpackage

// File: rtl/iaddr_access_chk.sv
module iaddr_access_chk
  import iaddr_pkg::*;
#(
  parameter bit NEED_READ = 1'b0
) (
  input  logic [1:0] mode_i,
  input  logic       exist_i,
  input  logic       exec_ok_i,
  input  logic       read_ok_i,
  output logic       fault_o
);
  logic prot;
  logic perm_bad;

  assign prot = (mode_i != MODE_MASTER);

  generate
    if (NEED_READ) begin : g_rd
      assign perm_bad = !exec_ok_i || !read_ok_i;
    end else begin : g_nrd
      assign perm_bad = !exec_ok_i;
    end
  endgenerate

  assign fault_o = !exist_i || (prot && perm_bad);

  // R4: an existing location is never a fault in master mode
  always_comb begin
    if (exist_i && mode_i == MODE_MASTER)
      a_master_ok_r4: assert (!fault_o);
  end
endmodule

// File: rtl/iaddr_next_sel.sv
module iaddr_next_sel
  import iaddr_pkg::*;
#(
  parameter int unsigned AW        = ADDR_W,
  parameter logic [AW-1:0] FETCH_VEC = 'h40,
  parameter logic [AW-1:0] NAO_VEC   = 'h4D
) (
  input  logic [AW-1:0] addr_i,
  input  logic          fetch_req_i,
  input  logic          end_i,
  input  logic          fetch_fault_i,
  input  logic          tgt_fault_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_ea_i,
  input  logic          indirect_i,
  input  logic          ptr_ok_i,
  input  logic          trap_req_i,
  input  logic [AW-1:0] trap_vec_i,
  output logic [AW-1:0] next_addr_o,
  output logic          trap_o,
  output cause_e        cause_o,
  output logic [AW-1:0] ret_o
);
  logic ptr_fault;
  logic br_fault;
  logic end_act;

  assign end_act   = end_i && !fetch_req_i;
  assign ptr_fault = br_taken_i && indirect_i && !ptr_ok_i;
  assign br_fault  = br_taken_i && (ptr_fault || tgt_fault_i);

  always_comb begin
    next_addr_o = addr_i;
    trap_o      = 1'b0;
    cause_o     = CAUSE_NONE;
    ret_o       = addr_i;
    if (fetch_req_i) begin
      if (fetch_fault_i) begin
        next_addr_o = FETCH_VEC;
        trap_o      = 1'b1;
        cause_o     = CAUSE_FETCH;
      end else begin
        next_addr_o = addr_i + AW'(1);
      end
    end else if (end_act) begin
      ret_o = addr_i - AW'(1);
      if (trap_req_i) begin
        next_addr_o = trap_vec_i;
        trap_o      = 1'b1;
        cause_o     = CAUSE_REQ;
      end else if (br_fault) begin
        next_addr_o = NAO_VEC;
        trap_o      = 1'b1;
        cause_o     = CAUSE_NAO;
      end else if (br_taken_i) begin
        next_addr_o = br_ea_i;
      end
    end
  end

  // R10: untaken branch never raises a nonallowed-operation trap
  always_comb begin
    if (!br_taken_i && !trap_req_i && end_act)
      a_untaken_quiet_r10: assert (!trap_o);
  end
endmodule

// File: rtl/iaddr_seq.sv
module iaddr_seq
  import iaddr_pkg::*;
#(
  parameter int unsigned AW        = ADDR_W,
  parameter logic [AW-1:0] FETCH_VEC = 'h40,
  parameter logic [AW-1:0] NAO_VEC   = 'h4D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          fetch_req_i,
  input  logic          end_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_ea_i,
  input  logic          indirect_i,
  input  logic          ptr_ok_i,
  input  logic          trap_req_i,
  input  logic [AW-1:0] trap_vec_i,
  input  logic          exist_i,
  input  logic          exec_ok_i,
  input  logic          read_ok_i,
  output logic [AW-1:0] chk_addr_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          trap_o,
  output logic [1:0]    trap_cause_o,
  output logic [AW-1:0] trap_ret_o
);
  logic [AW-1:0] addr_q, addr_d, ret_d, ret_q;
  logic          trap_d, trap_q;
  cause_e        cause_d, cause_q;
  logic          fetch_fault, tgt_fault;

  iaddr_access_chk #(.NEED_READ(1'b0)) i_fetch_chk (
    .mode_i   (mode_i),
    .exist_i  (exist_i),
    .exec_ok_i(exec_ok_i),
    .read_ok_i(read_ok_i),
    .fault_o  (fetch_fault)
  );

  iaddr_access_chk #(.NEED_READ(1'b1)) i_tgt_chk (
    .mode_i   (mode_i),
    .exist_i  (exist_i),
    .exec_ok_i(exec_ok_i),
    .read_ok_i(read_ok_i),
    .fault_o  (tgt_fault)
  );

  iaddr_next_sel #(.AW(AW), .FETCH_VEC(FETCH_VEC), .NAO_VEC(NAO_VEC)) i_next_sel (
    .addr_i       (addr_q),
    .fetch_req_i  (fetch_req_i),
    .end_i        (end_i),
    .fetch_fault_i(fetch_fault),
    .tgt_fault_i  (tgt_fault),
    .br_taken_i   (br_taken_i),
    .br_ea_i      (br_ea_i),
    .indirect_i   (indirect_i),
    .ptr_ok_i     (ptr_ok_i),
    .trap_req_i   (trap_req_i),
    .trap_vec_i   (trap_vec_i),
    .next_addr_o  (addr_d),
    .trap_o       (trap_d),
    .cause_o      (cause_d),
    .ret_o        (ret_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      trap_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
      ret_q   <= '0;
    end else begin
      addr_q  <= addr_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
      if (trap_d) ret_q <= ret_d;
    end
  end

  assign chk_addr_o   = (end_i && !fetch_req_i) ? br_ea_i : addr_q;
  assign fetch_addr_o = addr_q;
  assign trap_o       = trap_q;
  assign trap_cause_o = cause_q;
  assign trap_ret_o   = ret_q;

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && !fetch_fault |=> fetch_addr_o == $past(fetch_addr_o) + AW'(1));

  p_fetch_vec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && fetch_fault |=> trap_o && fetch_addr_o == FETCH_VEC
      && trap_ret_o == $past(fetch_addr_o));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !fetch_req_i && !br_taken_i && !trap_req_i |=> $stable(fetch_addr_o));

  p_rollback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !fetch_req_i && trap_req_i |=> trap_o && trap_cause_o == CAUSE_REQ
      && trap_ret_o == $past(fetch_addr_o) - AW'(1));

  p_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_i && !end_i |=> !trap_o && trap_cause_o == CAUSE_NONE);
endmodule

// File: tb/test_iaddr_seq.sv
module test_iaddr_seq;
  localparam int AW = 17;

  typedef struct packed {
    logic f, e, b, ind, pok, ext, ex, xo, ro;
    logic [1:0]    md;
    logic [AW-1:0] ea, tv, xa;
    logic          xt;
    logic [1:0]    xc;
    logic [AW-1:0] xr;
  } vec_t;

  localparam int NV = 21;
  // f e b ind pok ext ex xo ro md ea tv | exp addr trap cause ret
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h1,    0,2'd0,17'h0},    // R2
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h2,    0,2'd0,17'h0},    // R2
    '{0,1,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h2,    0,2'd0,17'h0},    // R5
    '{0,1,1,0,1,0,1,1,1,2'b00,17'h100,  17'h0,  17'h100,  0,2'd0,17'h0},    // R6
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h101,  0,2'd0,17'h0},    // R2
    '{0,1,1,1,0,0,1,1,1,2'b00,17'h200,  17'h0,  17'h4D,   1,2'd2,17'h100},  // R8
    '{1,0,0,0,1,0,0,1,1,2'b00,17'h0,    17'h0,  17'h40,   1,2'd1,17'h4D},   // R3
    '{1,0,0,0,1,0,1,0,1,2'b00,17'h0,    17'h0,  17'h40,   1,2'd1,17'h40},   // R3
    '{1,0,0,0,1,0,1,0,1,2'b01,17'h0,    17'h0,  17'h41,   0,2'd0,17'h40},   // R4
    '{0,1,1,0,1,0,1,0,0,2'b01,17'h300,  17'h0,  17'h300,  0,2'd0,17'h40},   // R4
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h301,  0,2'd0,17'h40},   // R2
    '{0,1,1,0,1,0,1,1,0,2'b10,17'h500,  17'h0,  17'h4D,   1,2'd2,17'h300},  // R9
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h4E,   0,2'd0,17'h300},  // R2
    '{0,1,0,1,0,0,0,0,0,2'b00,17'h600,  17'h0,  17'h4E,   0,2'd0,17'h300},  // R10 R8
    '{0,1,1,0,1,1,1,1,1,2'b00,17'h700,  17'h60, 17'h60,   1,2'd3,17'h4D},   // R7
    '{0,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h60,   0,2'd0,17'h4D},   // R13
    '{1,1,1,0,1,0,1,1,1,2'b00,17'h700,  17'h0,  17'h61,   0,2'd0,17'h4D},   // R12
    '{0,1,1,0,1,0,1,1,1,2'b11,17'h1FFFF,17'h0,  17'h1FFFF,0,2'd0,17'h4D},   // R6
    '{1,0,0,0,1,0,1,1,1,2'b00,17'h0,    17'h0,  17'h0,    0,2'd0,17'h4D},   // R2 wrap
    '{0,1,0,0,1,1,1,1,1,2'b00,17'h0,    17'h80, 17'h80,   1,2'd3,17'h1FFFF},// R7 wrap
    '{0,1,1,0,1,0,0,1,1,2'b01,17'h10,   17'h0,  17'h4D,   1,2'd2,17'h7F}    // R9 R4
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          fetch_req_i = 0, end_i = 0, br_taken_i = 0, indirect_i = 0;
  logic          ptr_ok_i = 1, trap_req_i = 0, exist_i = 1, exec_ok_i = 1, read_ok_i = 1;
  logic [AW-1:0] br_ea_i = '0, trap_vec_i = '0;
  logic [AW-1:0] chk_addr_o, fetch_addr_o, trap_ret_o;
  logic          trap_o;
  logic [1:0]    trap_cause_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  iaddr_seq i_iaddr_seq (
    .clk_i, .rst_ni, .mode_i, .fetch_req_i, .end_i, .br_taken_i, .br_ea_i,
    .indirect_i, .ptr_ok_i, .trap_req_i, .trap_vec_i, .exist_i, .exec_ok_i,
    .read_ok_i, .chk_addr_o, .fetch_addr_o, .trap_o, .trap_cause_o, .trap_ret_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_req_i = 0; end_i = 0; br_taken_i = 0; indirect_i = 0; ptr_ok_i = 1;
    trap_req_i = 0; exist_i = 1; exec_ok_i = 1; read_ok_i = 1; mode_i = 2'b00;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20;
    check("R1 reset", {fetch_addr_o, trap_o, trap_cause_o}, {17'h0, 1'b0, 2'd0});
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      fetch_req_i = v.f; end_i = v.e; br_taken_i = v.b; indirect_i = v.ind;
      ptr_ok_i = v.pok; trap_req_i = v.ext; exist_i = v.ex; exec_ok_i = v.xo;
      read_ok_i = v.ro; mode_i = v.md; br_ea_i = v.ea; trap_vec_i = v.tv;
      @(negedge clk_i);
      check($sformatf("vec %0d addr/trap/cause", i),
            {fetch_addr_o, trap_o, trap_cause_o}, {v.xa, v.xt, v.xc});
      if (v.xt) check($sformatf("vec %0d trap_ret", i), trap_ret_o, v.xr);
    end
    // R11: qualified address follows the path under check
    idle(); fetch_req_i = 1; #1;
    check("R11 fetch chk_addr", chk_addr_o, fetch_addr_o);
    fetch_req_i = 0; end_i = 1; br_taken_i = 1; br_ea_i = 17'h1234; #1;
    check("R11 end chk_addr", chk_addr_o, 17'h1234);
    fetch_req_i = 1; #1;
    check("R11 both chk_addr", chk_addr_o, 17'h4D);
    idle();
    @(negedge clk_i);
    check("R13 trap cleared", {trap_o, trap_cause_o}, 3'b000);
    // R1: mid-run reset
    rst_ni = 1'b0; #2;
    check("R1 async reset", {fetch_addr_o, trap_o, trap_cause_o}, {17'h0, 1'b0, 2'd0});
    @(negedge clk_i); rst_ni = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule